// File: doc/BRIEF.md
# Ring-Buffer Audio Playback Fetch Engine

This block reads playback audio out of a circular buffer in system memory and streams it, one sample per handshake, toward a serializer's sample FIFO. Software sets the buffer base (start address), the base address of the last valid burst slot, and an interrupt period counted in bursts. Each memory request covers one 256-byte burst. After the last slot has been fetched, the read pointer returns to the start address. The current read pointer is always visible, so software can compute the playback position by subtracting the start address.

Transfers run only while both the fill and the drain enables are set. Clearing either enable lets the burst in flight complete and then parks the engine with its pointer intact. A one-cycle init pulse reloads the pointer from the start address and clears the period counter. Each memory word can be used as one 32-bit sample, or it can be split into two 16-bit samples. A one-cycle interrupt pulse marks every completed period, and a sticky status flag records it until software clears the flag.

Top module: `ring_play_dma`

## Requirements
- R1: While idle with both `cfg_fill_en` and `cfg_drain_en` high, the block raises `mem_req_valid` with `mem_req_addr` equal to `rd_ptr`. It keeps both stable until `mem_req_ready`, then accepts exactly 64 response words (256 bytes), and `busy` stays high until the last word is accepted.
- R2: When a burst completes, `rd_ptr` advances by 256. If `rd_ptr` equalled `cfg_last_addr`, it loads `cfg_start_addr` instead.
- R3: No request is issued unless both enables are high. If either enable drops, the current burst still completes, no further burst starts, `rd_ptr` holds, and a later re-enable continues from that pointer.
- R4: A one-cycle `ptr_init` pulse loads `rd_ptr` from `cfg_start_addr` on the next edge and clears the period counter.
- R5: `period_irq` is a one-cycle pulse after every `cfg_period`-th completed burst. The count runs across ring wraps and pauses. A `cfg_period` of 0 gives no interrupt.
- R6: `irq_status` is set together with each `period_irq` and stays set until an `irq_clear` pulse. If both occur in the same cycle, the set wins.
- R7: With `cfg_pack16`=0, each memory word leaves unchanged as one sample, in address order.
- R8: With `cfg_pack16`=1, each word yields two samples. Bits 15:0 are sent first and bits 31:16 second, each placed in `smp_data[31:16]` with bits 15:0 zero.
- R9: While `smp_valid` is high and `smp_ready` is low, `smp_data` holds. Memory responses are back-pressured through `mem_rsp_ready`, so no word is lost.
- R10: After reset, `rd_ptr` is 0 and `busy`, `mem_req_valid`, `smp_valid`, `period_irq` and `irq_status` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_addr | input | 32 | Ring base address, 256-byte aligned |
| cfg_last_addr | input | 32 | Base address of the final burst slot |
| cfg_period | input | 16 | Bursts per period interrupt, 0 disables |
| cfg_pack16 | input | 1 | 1: two 16-bit samples per word |
| cfg_fill_en | input | 1 | Fill enable |
| cfg_drain_en | input | 1 | Drain enable |
| ptr_init | input | 1 | Pulse: reload pointer, clear period count |
| irq_clear | input | 1 | Pulse: clear sticky status |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_addr | output | 32 | Burst base address |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_ready | output | 1 | Response word accepted |
| mem_rsp_data | input | 32 | Response word |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Sample accepted |
| smp_data | output | 32 | Sample |
| rd_ptr | output | 32 | Current read pointer |
| busy | output | 1 | Burst in flight |
| period_irq | output | 1 | Period interrupt pulse |
| irq_status | output | 1 | Sticky period flag |

## Verification
Every cycle, the assertions check that the request stays stable until accepted, that the output sample holds under back-pressure, and that the pointer moves only on an init pulse or a burst completion, wrapping to the start address after the last slot. They also check that the interrupt lasts one cycle and comes with the sticky flag, and that no request starts while paused. Only the bench scenarios can show the full sample order in both packing modes, the exact interrupt count over wraps and pauses, the effect of the init pulse on the period counter, and the resumed position after a pause.

// File: rtl/ring_play_dma_pkg.sv
// Shared types for the ring-buffer playback fetch engine.
package ring_play_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/ring_ptr_unit.sv
// Read pointer and period logic. The pointer advances one burst per
// completion and wraps to the start after the last slot. The period counter
// runs across wraps and raises a pulse plus a sticky flag.
// Assumes: start and last are burst aligned, and init arrives while idle.
module ring_ptr_unit #(
    parameter int ADDR_W      = 32,
    parameter int BURST_BYTES = 256,
    parameter int PERIOD_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic [ADDR_W-1:0]   last_addr,
    input  logic [PERIOD_W-1:0] period,
    input  logic                init,
    input  logic                burst_done,
    input  logic                irq_clear,
    output logic [ADDR_W-1:0]   rd_ptr,
    output logic                period_irq,
    output logic                irq_status
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    logic [PERIOD_W-1:0] cnt;
    logic                hit;

    // Period match on the burst now completing.
    assign hit = burst_done && !init && (period != '0) && (cnt == period - 1'b1);

    // Pointer: reload on init, advance or wrap on each completed burst.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_ptr <= '0;
        else if (init)       rd_ptr <= start_addr;
        else if (burst_done) rd_ptr <= (rd_ptr == last_addr) ? start_addr : rd_ptr + STEP;
    end

    // Burst counter within the current period.
    always_ff @(posedge clk) begin
        if (!rst_n || init) cnt <= '0;
        else if (burst_done) cnt <= hit ? '0 : cnt + 1'b1;
    end

    // One-cycle interrupt pulse and sticky status (set wins over clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_irq <= 1'b0;
            irq_status <= 1'b0;
        end else begin
            period_irq <= hit;
            if (hit)            irq_status <= 1'b1;
            else if (irq_clear) irq_status <= 1'b0;
        end
    end
endmodule

// File: rtl/sample_unpack.sv
// Holds one memory word and emits it as one full-width sample, or as two
// half-width samples (low half first), left-justified. Back-pressures its input.
// Assumes: pack16 does not change while a word is held.
module sample_unpack #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack16,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int HALF_W = DATA_W / 2;

    logic              hold;
    logic              upper;
    logic [DATA_W-1:0] word;
    logic              last_part;
    logic [HALF_W-1:0] half;

    assign last_part = !pack16 || upper;
    assign in_ready  = !hold || (out_ready && last_part);
    assign out_valid = hold;
    assign half      = upper ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
    assign out_data  = pack16 ? {half, {HALF_W{1'b0}}} : word;

    // Word holding register and half selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= 1'b0;
            upper <= 1'b0;
            word  <= '0;
        end else if (in_valid && in_ready) begin
            hold  <= 1'b1;
            upper <= 1'b0;
            word  <= in_data;
        end else if (hold && out_ready) begin
            if (last_part) hold  <= 1'b0;
            else           upper <= 1'b1;
        end
    end
endmodule

// File: rtl/ring_play_dma.sv
// Top of the ring-buffer playback fetch engine. An idle/request/data
// sequencer fetches one burst at a time while both enables are set, feeds
// the words to the unpacker and reports each completion to the pointer unit.
// Assumes: the memory returns words only after the request is accepted.
module ring_play_dma #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BURST_BYTES = 256,
    parameter int PERIOD_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cfg_start_addr,
    input  logic [ADDR_W-1:0]   cfg_last_addr,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                cfg_pack16,
    input  logic                cfg_fill_en,
    input  logic                cfg_drain_en,
    input  logic                ptr_init,
    input  logic                irq_clear,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    output logic                mem_rsp_ready,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    output logic                smp_valid,
    input  logic                smp_ready,
    output logic [DATA_W-1:0]   smp_data,
    output logic [ADDR_W-1:0]   rd_ptr,
    output logic                busy,
    output logic                period_irq,
    output logic                irq_status
);
    import ring_play_dma_pkg::*;

    localparam int BEATS  = BURST_BYTES / (DATA_W / 8);
    localparam int BEAT_W = $clog2(BEATS);

    fetch_state_t      state;
    logic [BEAT_W-1:0] beat;
    logic              unpack_ready;
    logic              rsp_fire;
    logic              burst_done;
    logic              run;

    assign run           = cfg_fill_en && cfg_drain_en;
    assign mem_req_valid = (state == ST_REQ);
    assign mem_req_addr  = rd_ptr;
    assign mem_rsp_ready = (state == ST_DATA) && unpack_ready;
    assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;
    assign burst_done    = rsp_fire && (beat == BEAT_W'(BEATS - 1));
    assign busy          = (state != ST_IDLE);

    // Burst sequencer: start only when enabled, always finish a started burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (run) state <= ST_REQ;
                ST_REQ: if (mem_req_ready) begin
                    state <= ST_DATA;
                    beat  <= '0;
                end
                ST_DATA: if (rsp_fire) begin
                    beat <= beat + 1'b1;
                    if (burst_done) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    ring_ptr_unit #(
        .ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES), .PERIOD_W(PERIOD_W)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .start_addr(cfg_start_addr), .last_addr(cfg_last_addr),
        .period(cfg_period), .init(ptr_init), .burst_done(burst_done),
        .irq_clear(irq_clear), .rd_ptr(rd_ptr),
        .period_irq(period_irq), .irq_status(irq_status)
    );

    sample_unpack #(.DATA_W(DATA_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .pack16(cfg_pack16),
        .in_valid(mem_rsp_valid && (state == ST_DATA)), .in_ready(unpack_ready),
        .in_data(mem_rsp_data),
        .out_valid(smp_valid), .out_ready(smp_ready), .out_data(smp_data)
    );
endmodule

// File: rtl/ring_play_dma_chk.sv
// Cycle-level checks for ring_play_dma, attached with bind.
module ring_play_dma_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_start_addr,
    input logic [ADDR_W-1:0] cfg_last_addr,
    input logic              cfg_fill_en,
    input logic              cfg_drain_en,
    input logic              ptr_init,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              smp_valid,
    input logic              smp_ready,
    input logic [DATA_W-1:0] smp_data,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic              busy,
    input logic              burst_done,
    input logic              period_irq,
    input logic              irq_status
);
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done && !ptr_init && (rd_ptr == cfg_last_addr) |=> rd_ptr == $past(cfg_start_addr));

    a_r3_no_start_paused: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !(cfg_fill_en && cfg_drain_en) |=> !mem_req_valid);

    a_r3_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_init && !burst_done |=> $stable(rd_ptr));

    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |=> !period_irq);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> irq_status);

    a_r9_smp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && !smp_ready |=> smp_valid && $stable(smp_data));
endmodule

bind ring_play_dma ring_play_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_addr(cfg_start_addr), .cfg_last_addr(cfg_last_addr),
    .cfg_fill_en(cfg_fill_en), .cfg_drain_en(cfg_drain_en), .ptr_init(ptr_init),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .rd_ptr(rd_ptr), .busy(busy), .burst_done(burst_done),
    .period_irq(period_irq), .irq_status(irq_status)
);

// File: tb/ring_play_dma_bench.sv
module ring_play_dma_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BEATS      = 64;
    localparam int MAXS       = 2048;

    typedef struct packed {
        logic [31:0] start;
        logic [7:0]  nb;
        logic [15:0] period;
        logic        pack;
        logic [7:0]  total;
        logic        stall;
        logic        drop_fill;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h1000, 8'd4, 16'd2, 1'b0, 8'd4, 1'b0, 1'b1},
        '{32'h2000, 8'd3, 16'd2, 1'b0, 8'd6, 1'b1, 1'b0},
        '{32'h3000, 8'd2, 16'd3, 1'b1, 8'd5, 1'b1, 1'b1},
        '{32'h4000, 8'd1, 16'd1, 1'b1, 8'd3, 1'b0, 1'b0},
        '{32'h5000, 8'd5, 16'd0, 1'b0, 8'd2, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_start_addr = '0, cfg_last_addr = '0;
    logic [15:0] cfg_period = '0;
    logic        cfg_pack16 = 1'b0, cfg_fill_en = 1'b0, cfg_drain_en = 1'b0;
    logic        ptr_init = 1'b0, irq_clear = 1'b0;
    logic        mem_req_valid, mem_rsp_ready, smp_valid, busy, period_irq, irq_status;
    logic [31:0] mem_req_addr, smp_data, rd_ptr;
    logic        mem_req_ready = 1'b1;
    logic        smp_ready = 1'b1;
    logic        stall = 1'b0;

    // memory model: returns the byte address of each word as its data
    logic        m_active = 1'b0;
    logic [31:0] m_base = '0;
    int          m_idx = 0;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    assign mem_rsp_valid = m_active;
    assign mem_rsp_data  = m_base + 32'(m_idx * 4);

    int tests = 0, fails = 0, cyc = 0;
    int req_cnt = 0, irq_cnt = 0, got_n = 0;
    logic [31:0] got [MAXS];

    ring_play_dma u_ring_play_dma (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_valid && mem_req_ready) begin
            m_base <= mem_req_addr; m_idx <= 0; m_active <= 1'b1;
            req_cnt <= req_cnt + 1;
        end else if (m_active && mem_rsp_ready) begin
            m_idx <= m_idx + 1;
            if (m_idx == BEATS - 1) m_active <= 1'b0;
        end
        if (period_irq) irq_cnt <= irq_cnt + 1;
        if (smp_valid && smp_ready && got_n < MAXS) begin
            got[got_n] <= smp_data;
            got_n <= got_n + 1;
        end
    end

    always @(negedge clk) smp_ready <= stall ? ((cyc % 3) != 0) : 1'b1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input vec_t v);
        cfg_start_addr = v.start;
        cfg_last_addr  = v.start + 32'(v.nb) * 256 - 256;
        cfg_period     = v.period;
        cfg_pack16     = v.pack;
        stall          = v.stall;
    endtask

    task automatic do_init();
        @(negedge clk) ptr_init = 1'b1;
        @(negedge clk) ptr_init = 1'b0;
        irq_cnt = 0;
    endtask

    task automatic run_bursts(input int total, input logic drop_fill);
        req_cnt = 0; got_n = 0;
        @(negedge clk); cfg_fill_en = 1'b1; cfg_drain_en = 1'b1;
        while (req_cnt < total) @(negedge clk);
        if (drop_fill) cfg_fill_en = 1'b0; else cfg_drain_en = 1'b0;
        while (busy || smp_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        cfg_fill_en = 1'b0; cfg_drain_en = 1'b0;
    endtask

    function automatic logic [31:0] exp_smp(input logic [31:0] st, input int nb,
                                            input logic pk, input int b0, input int k);
        int spw = pk ? 2 : 1;
        int b   = b0 + k / (BEATS * spw);
        int r   = k % (BEATS * spw);
        logic [31:0] w = st + 32'((b % nb) * 256 + (r / spw) * 4);
        if (!pk) return w;
        return (r % 2) ? {w[31:16], 16'h0} : {w[15:0], 16'h0};
    endfunction

    task automatic check_samples(input string req, input logic [31:0] st, input int nb,
                                 input logic pk, input int b0, input int nbursts);
        int bad = 0;
        int n = nbursts * BEATS * (pk ? 2 : 1);
        chk({req, " sample count"}, 32'(got_n), 32'(n));
        for (int k = 0; k < n && k < got_n; k++)
            if (got[k] !== exp_smp(st, nb, pk, b0, k)) bad++;
        chk({req, " sample mismatches"}, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rd_ptr", rd_ptr, 32'h0);
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 req", 32'(mem_req_valid), 32'd0);
        chk("R10 smp_valid", 32'(smp_valid), 32'd0);
        chk("R10 irq", 32'({period_irq, irq_status}), 32'd0);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R5 R7 R8 R9
        for (int i = 0; i < 5; i++) begin
            vec_t v = VECS[i];
            int t = int'(v.total), nb = int'(v.nb), p = int'(v.period);
            setup(v);
            do_init();
            chk("R4 init reload", rd_ptr, v.start);
            run_bursts(t, v.drop_fill);
            chk("R3 exact burst count", 32'(req_cnt), 32'(t));
            check_samples(v.pack ? "R8" : "R7", v.start, nb, v.pack, 0, t);
            chk("R5 irq count", 32'(irq_cnt), 32'(p == 0 ? 0 : t / p));
            chk("R2 pointer", rd_ptr, v.start + 32'((t % nb) * 256));
            if (p != 0 && t >= p) begin
                chk("R6 status set", 32'(irq_status), 32'd1);
                @(negedge clk) irq_clear = 1'b1;
                @(negedge clk) irq_clear = 1'b0;
                chk("R6 status cleared", 32'(irq_status), 32'd0);
            end else begin
                chk("R6 status idle", 32'(irq_status), 32'd0);
            end
        end

        // R3 pause and resume, R5 count across the pause
        setup('{32'h6000, 8'd4, 16'd3, 1'b0, 8'd0, 1'b1, 1'b1});
        do_init();
        run_bursts(2, 1'b1);
        chk("R3 paused pointer", rd_ptr, 32'h6200);
        repeat (20) @(negedge clk);
        chk("R3 pointer held", rd_ptr, 32'h6200);
        chk("R3 idle while paused", 32'(busy), 32'd0);
        run_bursts(2, 1'b0);
        check_samples("R3 resume", 32'h6000, 4, 1'b0, 2, 2);
        chk("R5 count across pause", 32'(irq_cnt), 32'd1);
        chk("R2 wrap after resume", rd_ptr, 32'h6000);

        // R4 init clears the period counter (one burst into the period)
        do_init();
        run_bursts(2, 1'b1);
        chk("R4 period counter cleared", 32'(irq_cnt), 32'd0);
        chk("R4 pointer after init", rd_ptr, 32'h6200);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule